// File: doc/BRIEF.md
# Watchdog Timer with Reload and Two-Step Refresh

This block is a watchdog for a small 8-bit microcontroller. It is attached to a simple special-function-register (SFR) bus that has an address, write data, read data, a write strobe and a read strobe. A 15-bit up-counter runs from the block clock. It advances either on every cycle or, when software selects the slow rate, once every 16 cycles. When the counter overflows from all ones, the block asserts a reset request for two cycles. It also sets a sticky expiry flag, which that reset request does not clear.

Software keeps the system alive by refreshing the counter. A refresh needs a two-step handshake on a kick register. A write with the prime bit set must be followed by a write with the confirm bit set, and the confirm write must be the very next SFR write. A refresh clears the low byte of the counter and loads the upper seven bits from the reload register. The same load happens when the counter expires. Software reads the expiry flag from the status register and clears it by writing 0 to that bit.

Top module: `wdog_core`

## Requirements
- R1: After the synchronous reset `rst`, the reload register (address 0x86) and the status register (address 0xA9) read 0x00, the kick register (0xA8) and unmapped addresses read 0x00, and `wd_reset_o` is low. Read data appears on `sfr_rdata` in the cycle after the read strobe.
- R2: The reload register stores and reads back any 8-bit value. Bit 7 selects the slow rate, and bits 6..0 give the counter's upper seven bits. Writing the reload register does not by itself change the counter.
- R3: A refresh sets the counter to {reload[6:0], 8'h00}. With bit 7 clear, the counter advances once per cycle, and the first `wd_reset_o` cycle follows the refresh write's capture edge by exactly 0x8000 - reload[6:0]*256 cycles.
- R4: With reload bit 7 set, the counter advances once every 16 cycles, and the delay from refresh to expiry is 16 times the R3 value. A refresh also restarts the divide-by-16 stage.
- R5: A refresh happens only when a write to 0xA8 with bit 0 (prime) set is followed by a write to 0xA8 with bit 1 (confirm) set, with no SFR write between them. Idle cycles between the two writes are allowed. A confirm write without a preceding prime write has no effect.
- R6: Any other SFR write between the prime write and the confirm write cancels the handshake. SFR reads do not cancel it.
- R7: On expiry, `wd_reset_o` is high for exactly 2 cycles and the counter is reloaded from the reload register. Counting resumes after the pulse, so with no refresh the next rise comes 2 + (R3 or R4 delay) cycles after the previous rise.
- R8: Expiry sets status bit 6. The bit stays set through and after `wd_reset_o` until software writes 0 to it. Writing 1 to bit 6 never sets it. Only the external `rst` clears it otherwise.
- R9: Status bits other than bit 6 store the written value, are not changed by an expiry, and have no effect on watchdog timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_wr | input | 1 | SFR write strobe, one cycle per write |
| sfr_rd | input | 1 | SFR read strobe |
| sfr_rdata | output | 8 | Registered read data, valid the cycle after `sfr_rd` |
| wd_reset_o | output | 1 | Internal reset request, high for 2 cycles on expiry |

## Verification
The hardest situation to reach from the ports is a handshake that looks valid but must be rejected. One case is a confirm write that follows a prime write with some other SFR write between them. The other is a lone confirm write. The only visible sign of a refresh is when the next reset request arrives, so the bench starts each case with a refresh from a known reload value. It then places the handshake writes a fixed number of cycles later and measures the rise of `wd_reset_o` against a free-running cycle count. Two measures tell the outcomes apart: the interval from the original refresh means the handshake was ignored, and the interval from the confirm write means the refresh took place.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic {
    ARM_IDLE   = 1'b0,
    ARM_PRIMED = 1'b1
  } arm_state_e;

endpackage

// File: rtl/wdog_arm.sv
module wdog_arm
  import wdog_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRIME_BIT   = 0,
  parameter int CONFIRM_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              kick_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              refresh_o
);

  arm_state_e state_q;

  assign refresh_o = wr && kick_sel && wdata[CONFIRM_BIT] && (state_q == ARM_PRIMED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARM_IDLE;
    end else if (wr) begin
      if (refresh_o) begin
        state_q <= ARM_IDLE;
      end else if (kick_sel && wdata[PRIME_BIT]) begin
        state_q <= ARM_PRIMED;
      end else begin
        state_q <= ARM_IDLE;
      end
    end
  end

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PRE_LOG2 = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic slow,
  output logic tick_o
);

  generate
    if (PRE_LOG2 == 0) begin : g_none
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam logic [PRE_LOG2-1:0] PRE_MAX = '1;
      logic [PRE_LOG2-1:0] pre_q;

      always_ff @(posedge clk) begin
        if (rst || clear) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end

      assign tick_o = slow ? (pre_q == PRE_MAX) : 1'b1;
    end
  endgenerate

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int HI_W    = 7,
  parameter int LO_W    = 8,
  parameter int RST_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 refresh,
  input  logic [HI_W-1:0]      high,
  output logic                 expire_o,
  output logic                 hold_o,
  output logic [HI_W+LO_W-1:0] cnt_o,
  output logic [HI_W+LO_W-1:0] load_o
);

  localparam int CNT_W  = HI_W + LO_W;
  localparam int LEFT_W = $clog2(RST_CYC + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [LEFT_W-1:0] LEFT_INI = LEFT_W'(RST_CYC);

  logic [CNT_W-1:0]  cnt_q;
  logic [LEFT_W-1:0] left_q;

  assign load_o   = {high, {LO_W{1'b0}}};
  assign hold_o   = (left_q != '0);
  assign expire_o = !hold_o && !refresh && tick && (cnt_q == CNT_MAX);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      left_q <= '0;
    end else if (hold_o) begin
      cnt_q  <= load_o;
      left_q <= left_q - 1'b1;
    end else if (refresh) begin
      cnt_q <= load_o;
    end else if (expire_o) begin
      cnt_q  <= load_o;
      left_q <= LEFT_INI;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter int                HI_W        = 7,
  parameter int                FLAG_BIT    = 6,
  parameter logic [ADDR_W-1:0] RELOAD_ADDR = 8'h86,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 8'hA9,
  parameter logic [ADDR_W-1:0] KICK_ADDR   = 8'hA8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic [DATA_W-1:0] rdata_o,
  output logic              slow_o,
  output logic [HI_W-1:0]   high_o,
  output logic              flag_o,
  output logic              kick_sel_o
);

  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] stat_view;

  assign slow_o     = reload_q[HI_W];
  assign high_o     = reload_q[HI_W-1:0];
  assign flag_o     = stat_q[FLAG_BIT];
  assign kick_sel_o = (addr == KICK_ADDR);
  assign stat_view  = stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
    end else if (wr && addr == RELOAD_ADDR) begin
      reload_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      if (wr && addr == STAT_ADDR) begin
        for (int b = 0; b < DATA_W; b++) begin
          if (b != FLAG_BIT) stat_q[b] <= wdata[b];
        end
      end
      if (expire) begin
        stat_q[FLAG_BIT] <= 1'b1;
      end else if (wr && addr == STAT_ADDR && !wdata[FLAG_BIT]) begin
        stat_q[FLAG_BIT] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd) begin
      if (addr == RELOAD_ADDR)    rdata_o <= reload_q;
      else if (addr == STAT_ADDR) rdata_o <= stat_view;
      else                        rdata_o <= '0;
    end
  end

endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter int                HI_W        = 7,
  parameter int                LO_W        = 8,
  parameter int                PRE_LOG2    = 4,
  parameter int                RST_CYC     = 2,
  parameter int                FLAG_BIT    = 6,
  parameter int                PRIME_BIT   = 0,
  parameter int                CONFIRM_BIT = 1,
  parameter logic [ADDR_W-1:0] RELOAD_ADDR = 8'h86,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 8'hA9,
  parameter logic [ADDR_W-1:0] KICK_ADDR   = 8'hA8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_wr,
  input  logic              sfr_rd,
  output logic [DATA_W-1:0] sfr_rdata,
  output logic              wd_reset_o
);

  localparam int CNT_W = HI_W + LO_W;

  logic             expire;
  logic             hold;
  logic             refresh;
  logic             tick;
  logic             slow;
  logic             flag_q;
  logic             kick_sel;
  logic [HI_W-1:0]  high;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  wdog_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_W(HI_W), .FLAG_BIT(FLAG_BIT),
    .RELOAD_ADDR(RELOAD_ADDR), .STAT_ADDR(STAT_ADDR), .KICK_ADDR(KICK_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(sfr_wr), .rd(sfr_rd), .addr(sfr_addr),
    .wdata(sfr_wdata), .expire(expire), .rdata_o(sfr_rdata), .slow_o(slow),
    .high_o(high), .flag_o(flag_q), .kick_sel_o(kick_sel)
  );

  wdog_arm #(
    .DATA_W(DATA_W), .PRIME_BIT(PRIME_BIT), .CONFIRM_BIT(CONFIRM_BIT)
  ) u_arm (
    .clk(clk), .rst(rst), .wr(sfr_wr), .kick_sel(kick_sel),
    .wdata(sfr_wdata), .refresh_o(refresh)
  );

  wdog_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst(rst), .clear(refresh | expire | hold), .slow(slow), .tick_o(tick)
  );

  wdog_count #(.HI_W(HI_W), .LO_W(LO_W), .RST_CYC(RST_CYC)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .refresh(refresh), .high(high),
    .expire_o(expire), .hold_o(hold), .cnt_o(cnt_q), .load_o(load_val)
  );

  assign wd_reset_o = hold;

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int                CNT_W     = 15,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter int                FLAG_BIT  = 6,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hA9
) (
  input logic              clk,
  input logic              rst,
  input logic              wd_reset,
  input logic              flag,
  input logic              refresh,
  input logic              expire,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  load,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata
);

  a_r7_pulse_second: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_reset) |=> wd_reset);

  a_r7_pulse_ends: assert property (@(posedge clk) disable iff (rst)
    (wd_reset && $past(wd_reset)) |=> !wd_reset);

  a_r7_expiry_starts_pulse: assert property (@(posedge clk) disable iff (rst)
    expire |=> $rose(wd_reset));

  a_r8_flag_on_expiry: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !(wr && addr == STAT_ADDR && !wdata[FLAG_BIT])) |=> flag);

  a_r3_refresh_loads: assert property (@(posedge clk) disable iff (rst)
    refresh |=> (cnt == $past(load)));

  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (!refresh && !wd_reset && !expire) |=>
      (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

endmodule

bind wdog_core wdog_chk #(
  .CNT_W(HI_W + LO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .FLAG_BIT(FLAG_BIT), .STAT_ADDR(STAT_ADDR)
) u_wdog_chk (
  .clk(clk), .rst(rst), .wd_reset(wd_reset_o), .flag(flag_q),
  .refresh(refresh), .expire(expire), .cnt(cnt_q), .load(load_val),
  .wr(sfr_wr), .addr(sfr_addr), .wdata(sfr_wdata)
);

// File: tb/test_wdog_core.sv
module test_wdog_core;

  localparam logic [7:0] A_RELOAD = 8'h86;
  localparam logic [7:0] A_STAT   = 8'hA9;
  localparam logic [7:0] A_KICK   = 8'hA8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sfr_addr = '0;
  logic [7:0] sfr_wdata = '0;
  logic       sfr_wr = 1'b0;
  logic       sfr_rd = 1'b0;
  logic [7:0] sfr_rdata;
  logic       wd_reset_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_core i_wdog_core (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata), .wd_reset_o(wd_reset_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_sfr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic rd_sfr(input logic [7:0] a, output logic [7:0] d);
    sfr_addr = a; sfr_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    sfr_rd = 1'b0;
    d = sfr_rdata;
  endtask

  task automatic kick(output int t);
    wr_sfr(A_KICK, 8'h01);
    wr_sfr(A_KICK, 8'h02);
    t = cyc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rise(output int t);
    int g = 0;
    while (!wd_reset_o && g < 40000) begin
      @(negedge clk);
      g++;
    end
    if (g >= 40000) begin
      checks++; errors++;
      $display("FAIL timeout actual=%0d expected=1", wd_reset_o);
    end
    t = cyc;
  endtask

  task automatic settle();
    while (wd_reset_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    int t0, t1, t2;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 reset pin", int'(wd_reset_o), 0);
    rd_sfr(A_RELOAD, d); chk("R1 reload reset", d, 0);
    rd_sfr(A_STAT, d);   chk("R1 status reset", d, 0);
    rd_sfr(A_KICK, d);   chk("R1 kick reads 0", d, 0);
    rd_sfr(8'h00, d);    chk("R1 unmapped reads 0", d, 0);

    // R2 reload sweep
    for (int v = 0; v < 256; v++) begin
      wr_sfr(A_RELOAD, 8'(v));
      rd_sfr(A_RELOAD, d);
      chk("R2 reload readback", d, v);
    end
    // R9 status sweep (flag clear, writing 1 never sets it - R8)
    for (int v = 0; v < 256; v++) begin
      wr_sfr(A_STAT, 8'(v));
      rd_sfr(A_STAT, d);
      chk("R9 R8 status store", d, v & 8'hBF);
    end
    wr_sfr(A_STAT, 8'h00);

    // R3 fast-rate intervals
    for (int k = 0; k < 4; k++) begin
      logic [6:0] r;
      r = (k == 0) ? 7'h7F : (k == 1) ? 7'h7E : (k == 2) ? 7'h7C : 7'h70;
      wr_sfr(A_RELOAD, {1'b0, r});
      kick(t0);
      wait_rise(t1);
      chk("R3 expiry interval", t1 - t0, 32768 - int'(r) * 256);
      settle();
    end
    rd_sfr(A_STAT, d);
    chk("R8 flag after expiry", d, 8'h40);

    // R4 slow-rate intervals
    wr_sfr(A_RELOAD, 8'hFF);
    kick(t0); wait_rise(t1);
    chk("R4 slow interval 0x7F", t1 - t0, 4096);
    settle();
    wr_sfr(A_RELOAD, 8'hFE);
    kick(t0); wait_rise(t1);
    chk("R4 slow interval 0x7E", t1 - t0, 8192);
    settle();

    // R7 pulse length and free-running period
    wr_sfr(A_RELOAD, 8'h7F);
    kick(t0); wait_rise(t1);
    chk("R7 first rise", t1 - t0, 256);
    @(negedge clk); chk("R7 pulse cycle 2", int'(wd_reset_o), 1);
    @(negedge clk); chk("R7 pulse ends", int'(wd_reset_o), 0);
    wait_rise(t2);
    chk("R7 period", t2 - t1, 258);
    settle();

    // R8 flag sticky, write-1 ignored, write-0 clears
    rd_sfr(A_STAT, d); chk("R8 flag survives pulse", d, 8'h40);
    wr_sfr(A_STAT, 8'h40);
    rd_sfr(A_STAT, d); chk("R8 write 1 keeps", d, 8'h40);
    wr_sfr(A_STAT, 8'h00);
    rd_sfr(A_STAT, d); chk("R8 write 0 clears", d, 8'h00);

    // R9 other bits kept through expiry and no timing effect
    wr_sfr(A_STAT, 8'hBF);
    kick(t0); wait_rise(t1);
    chk("R9 timing unaffected", t1 - t0, 256);
    settle();
    rd_sfr(A_STAT, d); chk("R9 bits kept on expiry", d, 8'hFF);
    wr_sfr(A_STAT, 8'h15);

    // R5 confirm alone ignored
    kick(t0); idle(50);
    wr_sfr(A_KICK, 8'h02);
    wait_rise(t1);
    chk("R5 lone confirm ignored", t1 - t0, 256);
    settle();

    // R5 prime, idle gap, confirm refreshes
    kick(t0); idle(50);
    wr_sfr(A_KICK, 8'h01); idle(5);
    wr_sfr(A_KICK, 8'h02); t2 = cyc;
    wait_rise(t1);
    chk("R5 idle gap refresh", t1 - t2, 256);
    settle();

    // R6 intervening write cancels
    kick(t0); idle(50);
    wr_sfr(A_KICK, 8'h01);
    wr_sfr(A_STAT, 8'h15);
    wr_sfr(A_KICK, 8'h02);
    wait_rise(t1);
    chk("R6 write disarms", t1 - t0, 256);
    settle();

    // R6 intervening read keeps the handshake
    kick(t0); idle(50);
    wr_sfr(A_KICK, 8'h01);
    rd_sfr(A_RELOAD, d);
    wr_sfr(A_KICK, 8'h02); t2 = cyc;
    wait_rise(t1);
    chk("R6 read keeps arm", t1 - t2, 256);
    settle();

    // R8 external reset clears flag; R1 values after reset
    rd_sfr(A_STAT, d); chk("R8 flag set before rst", d, 8'h55);
    rst = 1'b1; idle(2); rst = 1'b0; @(negedge clk);
    rd_sfr(A_STAT, d);   chk("R8 R1 rst clears status", d, 0);
    rd_sfr(A_RELOAD, d); chk("R1 rst clears reload", d, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule